// File: doc/BRIEF.md
# Infrared Mode Gate and Slow-Rate Pulse Transmitter

The block holds the configuration of an infrared port and drives its slow-rate transmit path. Software programs a mode register and a "next" physical-layer word through a small register port. Neither takes effect when it is written. Both are applied together when the enable bit goes from 0 to 1. The applied physical-layer word is then readable from a separate current-word register, and a status register reports the mode that is actually in use.

Once slow-rate (SIR) mode is applied and transmission is enabled, the block accepts bytes on a ready/valid input. It sends each byte as an asynchronous character: one start bit of zero, eight data bits with the least significant bit first, then one stop bit of one. Every zero bit produces one narrow pulse at the start of its bit period. A one bit leaves the line idle.

Two fields of the applied word set the timing. The baud field gives the bit period in ticks of a 16x sample enable: 16·(baud+1) ticks per bit. The sample enable is produced from the system clock by a phase accumulator. The width field gives the pulse length in width ticks. Each width step lasts (baud+1) of those ticks, and each width tick lasts PW_DIV clock cycles. A typical setting is PW_DIV = 5, which gives an 8 MHz width tick from a 40 MHz clock.

Top module: `irsir_tx_top`

## Requirements
- R1: After reset, all four readable registers read 0, `tx_ready_o` is 0 and `ir_tx_o` is 0.
- R2: Address 0 is the mode register: bit0 sir, bit1 mir, bit2 fir, bit3 crc16, bit4 tx enable, bit5 rx enable, bit6 loopback, bit7 tx invert. Address 1 is the next physical-layer word: baud [15:10], width [9:5], preamble [4:0]. Both read back what was written. Address 3, the current word, changes only on a 0→1 write to enable bit 0 at address 2, and then takes the value of address 1.
- R3: Status at address 2 has these bits: bit0 enable, bit1 config error, bit2 sir_on, bit3 mir_on, bit4 fir_on, bit5 crc16_on, bit6 tx status, bit7 rx status. On the enable rising edge with at most one of sir/mir/fir set, the matching on-bit is set. On-bits stay fixed while enabled, even if the mode register is rewritten. Writing enable to 0 clears them.
- R4: If more than one of sir/mir/fir is set at the enable rising edge, config error is set and all three on-bits stay 0.
- R5: Tx status always equals the mode register's tx enable. Rx status always equals rx_en AND (NOT tx_en OR loopback).
- R6: crc16_on takes the mode register's crc16 bit at the enable rising edge and is cleared by disable.
- R7: `tx_ready_o` is 1 only when enable, sir_on and tx enable are all set and no character is being sent.
- R8: An accepted byte is sent as 10 bit periods: start bit 0, data LSB first, stop bit 1. Each bit period lasts 16·(baud+1) sample ticks. A pulse begins in the first cycle of every zero bit. One bits produce no pulse.
- R9: Each pulse lasts PW_DIV·(baud+1)·(width+1) clock cycles.
- R10: When mode bit7 is 1, `ir_tx_o` is the inverse of the pulse signal, including while idle.
- R11: `tx_ready_o` is 0 for the whole character and returns to 1 in the cycle right after the tenth bit period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Combinational read data at `addr_i` |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Byte valid |
| tx_ready_o | output | 1 | Transmitter can accept a byte |
| ir_tx_o | output | 1 | Infrared transmit pulse output |

## Verification
The bench covers the following corner cases:
- Several mode bits set at the moment enable rises. A design that checked the error only when the mode register is written would report a mode that is on and no error.
- Writing the next word while the port is enabled. A design that passes the word straight through would show the new value as current before the next enable edge.
- Tx status and rx status for every combination of tx enable, rx enable and loopback.
- All-zero, all-one and alternating bytes, at widths 0 and 31, at several baud values and with the inverted polarity. These catch bit-order errors, a pulse emitted on one bits, and off-by-one errors in the bit period or the pulse length. Each of these shows up as a misplaced or wrongly sized pulse in the cycle-by-cycle comparison.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;

  localparam logic [REG_AW-1:0] ADDR_MODE = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_NEXT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_CUR  = 2'd3;

  localparam int BAUD_W  = 6;
  localparam int WIDTH_W = 5;
  localparam int PRE_W   = 5;
  localparam int FRAME_BITS = 10;

  typedef struct packed {
    logic [BAUD_W-1:0]  baud;
    logic [WIDTH_W-1:0] width;
    logic [PRE_W-1:0]   preamb;
  } phy_word_t;

  typedef struct packed {
    logic tx_inv;
    logic loop;
    logic rx_en;
    logic tx_en;
    logic crc16;
    logic fir;
    logic mir;
    logic sir;
  } mode_t;

  typedef struct packed {
    logic rx_st;
    logic tx_st;
    logic crc16_on;
    logic fir_on;
    logic mir_on;
    logic sir_on;
    logic cfg_err;
    logic enabled;
  } status_t;
endpackage

// File: rtl/irsir_cfg_gate.sv
module irsir_cfg_gate
  import irsir_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wr_data_i,
  output logic [REG_DW-1:0] rd_data_o,
  output logic              active_o,
  output logic              tx_inv_o,
  output phy_word_t         cur_phy_o
);
  mode_t     mode_q;
  phy_word_t next_q, cur_q;
  logic      en_q, err_q, sir_on_q, mir_on_q, fir_on_q, crc_on_q;

  logic       wr_en_reg, en_rise, en_fall;
  logic [1:0] n_modes;
  status_t    stat;

  assign wr_en_reg = wr_en_i && (addr_i == ADDR_STAT);
  assign en_rise   = wr_en_reg && wr_data_i[0] && !en_q;
  assign en_fall   = wr_en_reg && !wr_data_i[0] && en_q;
  assign n_modes   = {1'b0, mode_q.sir} + {1'b0, mode_q.mir} + {1'b0, mode_q.fir};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      next_q   <= '0;
      cur_q    <= '0;
      en_q     <= 1'b0;
      err_q    <= 1'b0;
      sir_on_q <= 1'b0;
      mir_on_q <= 1'b0;
      fir_on_q <= 1'b0;
      crc_on_q <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_MODE) mode_q <= mode_t'(wr_data_i[7:0]);
      if (wr_en_i && addr_i == ADDR_NEXT) next_q <= phy_word_t'(wr_data_i);
      if (en_rise) begin
        en_q     <= 1'b1;
        cur_q    <= next_q;
        err_q    <= (n_modes > 2'd1);
        sir_on_q <= mode_q.sir && (n_modes == 2'd1);
        mir_on_q <= mode_q.mir && (n_modes == 2'd1);
        fir_on_q <= mode_q.fir && (n_modes == 2'd1);
        crc_on_q <= mode_q.crc16;
      end else if (en_fall) begin
        en_q     <= 1'b0;
        err_q    <= 1'b0;
        sir_on_q <= 1'b0;
        mir_on_q <= 1'b0;
        fir_on_q <= 1'b0;
        crc_on_q <= 1'b0;
      end
    end
  end

  always_comb begin
    stat.enabled  = en_q;
    stat.cfg_err  = err_q;
    stat.sir_on   = sir_on_q;
    stat.mir_on   = mir_on_q;
    stat.fir_on   = fir_on_q;
    stat.crc16_on = crc_on_q;
    stat.tx_st    = mode_q.tx_en;
    stat.rx_st    = mode_q.rx_en && (!mode_q.tx_en || mode_q.loop);
    unique case (addr_i)
      ADDR_MODE: rd_data_o = {8'h00, mode_q};
      ADDR_NEXT: rd_data_o = next_q;
      ADDR_STAT: rd_data_o = {8'h00, stat};
      default:   rd_data_o = cur_q;
    endcase
  end

  assign active_o  = en_q && sir_on_q && mode_q.tx_en;
  assign tx_inv_o  = mode_q.tx_inv;
  assign cur_phy_o = cur_q;

  // R4
  cfg_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !(sir_on_q || mir_on_q || fir_on_q));

  // R3
  on_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sir_on_q, mir_on_q, fir_on_q}));

  // R2
  cur_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> $stable(cur_q));
endmodule

// File: rtl/irsir_tick_gen.sv
module irsir_tick_gen #(
  parameter int CLK_HZ  = 40_000_000,
  parameter int SAMP_HZ = 1_843_200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int ACC_W = $clog2(CLK_HZ + SAMP_HZ) + 1;
  localparam logic [ACC_W-1:0] CLK_V  = ACC_W'(CLK_HZ);
  localparam logic [ACC_W-1:0] SAMP_V = ACC_W'(SAMP_HZ);

  logic [ACC_W-1:0] acc_q, acc_sum;

  assign acc_sum = acc_q + SAMP_V;
  assign tick_o  = !restart_i && (acc_sum >= CLK_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (restart_i) acc_q <= '0;
    else if (tick_o)    acc_q <= acc_sum - CLK_V;
    else                acc_q <= acc_sum;
  end

  // R8
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < CLK_V);
endmodule

// File: rtl/irsir_serializer.sv
module irsir_serializer
  import irsir_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [7:0]        tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              accept_o,
  output logic              fire_o
);
  localparam int TCNT_W = BAUD_W + 4;
  localparam int IDX_W  = $clog2(FRAME_BITS);

  logic                  busy_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [TCNT_W-1:0]     tcnt_q;
  logic [TCNT_W-1:0]     tlim;
  logic                  bit_end, last_bit;

  assign tlim       = {baud_i, 4'hF};
  assign tx_ready_o = active_i && !busy_q;
  assign accept_o   = tx_ready_o && tx_valid_i;
  assign bit_end    = busy_q && tick_i && (tcnt_q == tlim);
  assign last_bit   = (idx_q == IDX_W'(FRAME_BITS - 1));
  assign fire_o     = accept_o || (bit_end && !last_bit && !sh_q[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      tcnt_q <= '0;
    end else if (!active_i) begin
      busy_q <= 1'b0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, tx_data_i, 1'b0};
      idx_q  <= '0;
      tcnt_q <= '0;
    end else if (busy_q && tick_i) begin
      if (tcnt_q == tlim) begin
        tcnt_q <= '0;
        if (last_bit) busy_q <= 1'b0;
        else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
        end
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !tx_ready_o);
endmodule

// File: rtl/irsir_pulse_gen.sv
module irsir_pulse_gen
  import irsir_pkg::*;
#(
  parameter int PW_DIV = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               fire_i,
  input  logic [BAUD_W-1:0]  baud_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pulse_o
);
  localparam int PW_W = (PW_DIV > 1) ? $clog2(PW_DIV) : 1;
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(PW_DIV - 1);

  logic [PW_W-1:0]    pw_q;
  logic [BAUD_W-1:0]  bd_q;
  logic [WIDTH_W-1:0] w_q;
  logic               pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      pw_q    <= '0;
      bd_q    <= '0;
      w_q     <= '0;
    end else if (abort_i) begin
      pulse_q <= 1'b0;
    end else if (fire_i) begin
      pulse_q <= 1'b1;
      pw_q    <= '0;
      bd_q    <= '0;
      w_q     <= '0;
    end else if (pulse_q) begin
      if (pw_q == PW_LAST) begin
        pw_q <= '0;
        if (bd_q == baud_i) begin
          bd_q <= '0;
          if (w_q == width_i) pulse_q <= 1'b0;
          else                w_q <= w_q + 1'b1;
        end else begin
          bd_q <= bd_q + 1'b1;
        end
      end else begin
        pw_q <= pw_q + 1'b1;
      end
    end
  end

  assign pulse_o = pulse_q;

  // R8
  fire_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !abort_i) |=> pulse_q);
endmodule

// File: rtl/irsir_tx_top.sv
module irsir_tx_top
  import irsir_pkg::*;
#(
  parameter int CLK_HZ  = 40_000_000,
  parameter int SAMP_HZ = 1_843_200,
  parameter int PW_DIV  = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [1:0]  addr_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic        ir_tx_o
);
  logic      active, tx_inv, tick, accept, fire, pulse;
  phy_word_t cur_phy;

  irsir_cfg_gate u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .rd_data_o,
    .active_o(active), .tx_inv_o(tx_inv), .cur_phy_o(cur_phy)
  );

  irsir_tick_gen #(.CLK_HZ(CLK_HZ), .SAMP_HZ(SAMP_HZ)) u_tick (
    .clk_i, .rst_ni, .restart_i(accept), .tick_o(tick)
  );

  irsir_serializer u_ser (
    .clk_i, .rst_ni, .active_i(active), .tick_i(tick), .baud_i(cur_phy.baud),
    .tx_data_i, .tx_valid_i, .tx_ready_o, .accept_o(accept), .fire_o(fire)
  );

  irsir_pulse_gen #(.PW_DIV(PW_DIV)) u_pulse (
    .clk_i, .rst_ni, .abort_i(!active), .fire_i(fire),
    .baud_i(cur_phy.baud), .width_i(cur_phy.width), .pulse_o(pulse)
  );

  assign ir_tx_o = pulse ^ tx_inv;
endmodule

// File: tb/sim_irsir_tx_top.sv
module sim_irsir_tx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  txd = '0;
  logic        txv = 1'b0;
  logic        txr, irtx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  irsir_tx_top #(.CLK_HZ(4), .SAMP_HZ(1), .PW_DIV(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .tx_data_i(txd),
    .tx_valid_i(txv), .tx_ready_o(txr), .ir_tx_o(irtx)
  );

  always #10 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [15:0] phy(int b, int w);
    return 16'((b << 10) | (w << 5));
  endfunction

  function automatic logic exp_bit(logic [7:0] d, int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return d[i-1];
  endfunction

  task automatic setup(int b, int w, logic inv);
    wr(2'd2, 16'h0000);
    wr(2'd0, {8'h00, inv, 7'b0010001});
    wr(2'd1, phy(b, w));
    wr(2'd2, 16'h0001);
  endtask

  task automatic send(logic [7:0] d, int b, int w, logic inv);
    int nb = 64 * (b + 1);
    int pl = (b + 1) * (w + 1);
    int bad_c = -1;
    logic bad_v = 1'b0;
    logic e;
    @(negedge clk);
    txd = d; txv = 1'b1;
    while (!txr) @(negedge clk);
    @(negedge clk);
    txv = 1'b0;
    for (int c = 0; c <= 10 * nb; c++) begin
      if (c < 10 * nb) e = (!exp_bit(d, c / nb) && (c % nb) < pl) ^ inv;
      else             e = inv;
      if (irtx !== e && bad_c < 0) begin bad_c = c; bad_v = irtx; end
      if (c == 10 * nb - 1) chk("R11 ready low in last cycle", 32'(txr), 32'd0);
      if (c == 10 * nb)     chk("R11 ready back after frame", 32'(txr), 32'd1);
      @(negedge clk);
    end
    checks++;
    if (bad_c >= 0) begin
      errors++;
      $display("FAIL R8/R9/R10 byte=%h b=%0d w=%0d inv=%0d cycle=%0d actual=%0d expected=%0d",
               d, b, w, inv, bad_c, bad_v, ~bad_v);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset register", 32'(v), 32'd0);
    end
    chk("R1 reset ready", 32'(txr), 32'd0);
    chk("R1 reset output", 32'(irtx), 32'd0);

    // R2, R4
    wr(2'd0, 16'h0007);
    wr(2'd1, 16'h1234);
    rd(2'd0, v); chk("R2 mode readback", 32'(v), 32'h07);
    rd(2'd1, v); chk("R2 next readback", 32'(v), 32'h1234);
    rd(2'd3, v); chk("R2 current before enable", 32'(v), 32'h0);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R4 config error, no mode on", 32'(v), 32'h03);
    rd(2'd3, v); chk("R2 current after enable", 32'(v), 32'h1234);
    wr(2'd1, 16'hABCD);
    rd(2'd3, v); chk("R2 current held while enabled", 32'(v), 32'h1234);
    chk("R7 ready with error", 32'(txr), 32'd0);

    // R3, R6
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R3 disable clears status", 32'(v), 32'h00);
    wr(2'd0, 16'h001A);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R3 R6 mir and crc16 on", 32'(v), 32'h69);
    rd(2'd3, v); chk("R2 new current word", 32'(v), 32'hABCD);
    chk("R7 ready without sir", 32'(txr), 32'd0);

    // R5 and R3 hold while enabled
    wr(2'd0, 16'h0021);
    rd(2'd2, v); chk("R5 rx only", 32'(v), 32'hA9);
    wr(2'd0, 16'h0031);
    rd(2'd2, v); chk("R5 tx blocks rx", 32'(v), 32'h69);
    wr(2'd0, 16'h0071);
    rd(2'd2, v); chk("R5 loopback", 32'(v), 32'hE9);
    wr(2'd0, 16'h0001);
    rd(2'd2, v); chk("R5 R3 nothing enabled, mode held", 32'(v), 32'h29);

    // R10 idle polarity, R7 gating
    setup(0, 0, 1'b1);
    rd(2'd2, v); chk("R3 sir on", 32'(v), 32'h45);
    chk("R10 idle inverted", 32'(irtx), 32'd1);
    chk("R7 ready when sir tx enabled", 32'(txr), 32'd1);
    wr(2'd0, 16'h0081);
    chk("R7 ready drops with tx enable", 32'(txr), 32'd0);

    // R8 R9 directed
    setup(0, 0, 1'b0);
    send(8'h00, 0, 0, 1'b0);
    send(8'hFF, 0, 0, 1'b0);
    send(8'h55, 0, 0, 1'b0);
    setup(1, 31, 1'b0);
    send(8'hA3, 1, 31, 1'b0);
    setup(2, 12, 1'b1);
    send(8'h0F, 2, 12, 1'b1);

    // random
    for (int n = 0; n < 12; n++) begin
      int b = int'($urandom_range(0, 2));
      int w = int'($urandom_range(0, 31));
      logic inv = 1'($urandom_range(0, 1));
      logic [7:0] d = 8'($urandom);
      setup(b, w, inv);
      send(d, b, w, inv);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule